// File: doc/BRIEF.md
# Conditional Execution Gate with IT-Block Tracking

This block decides, for every issued instruction, whether the instruction takes effect. It compares a 4-bit condition code against the four status flags: negative (N), zero (Z), carry (C) and overflow (V). The execute decision is combinational, so the issue stage can use it in the same cycle.

The block also holds an 8-bit state register for If-Then (IT) blocks in the compact instruction set. An IT instruction loads the register. Each instruction issued inside the block then advances it. While a block is active, the condition comes from the upper nibble of the state, and the instruction's own condition field is ignored. The state clears itself once the last instruction of the block has issued.

Flag generation and instruction decode sit in neighbouring blocks.

Top module: `cond_exec_tracker`

## Requirements
- R1: A synchronous active-high reset clears the IT state to 0x00 on the next clock edge. After reset, `in_block_o` is 0.
- R2: Condition codes 1110 and 1111 always give `exec_o` = 1, whatever the flags are.
- R3: The codes 0000 through 0111 each test one flag. An even code gives 1 when the flag is set, and the odd code that follows it gives 1 when the flag is clear. The flags are tested in this order: 0000/0001 test Z, 0010/0011 test C, 0100/0101 test N, 0110/0111 test V.
- R4: Code 1000 gives 1 only when C=1 and Z=0. Code 1001 gives the inverse.
- R5: Code 1010 gives 1 when N equals V. Code 1011 gives 1 when N differs from V.
- R6: Code 1100 gives 1 when Z=0 and N equals V. Code 1101 gives 1 when Z=1 or N differs from V.
- R7: A block is active, and `in_block_o` is 1, exactly when state bits 3:0 are nonzero. While a block is active, the condition is state bits 7:4 and `insn_cond_i` has no effect on `exec_o`.
- R8: `it_load_i` writes `it_value_i` into the state on the next edge. It takes priority over any advance in the same cycle.
- R9: An `issue_i` pulse while a block is active and no load is present advances the state. Bits 7:5 are kept and bits 4:0 shift left by one place, with a 0 entering bit 0 and the old bit 4 dropped.
- R10: If bits 3:0 are zero after an advance, the whole state becomes 0x00.
- R11: Without a load, the state holds its value when `issue_i` is low or when no block is active.
- R12: `exec_o` follows changes of the flags and of the condition within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction issues this cycle |
| it_load_i | input | 1 | Load the IT state from `it_value_i` |
| it_value_i | input | 8 | New IT state value |
| insn_cond_i | input | 4 | Condition field of the issued instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| exec_o | output | 1 | Instruction should execute |
| in_block_o | output | 1 | An IT block is active |
| it_state_o | output | 8 | Current IT state |

## Verification
A corrupted IT state is visible in the same cycle it appears, because `it_state_o` and `in_block_o` expose it directly. It also changes `exec_o` at the next issue inside the block, because the upper nibble selects the condition. A faulty advance shows one edge after the issue pulse, either as a wrong shifted value or as a block that fails to close. A wrong entry in the condition table shows combinationally, for a specific pair of condition code and flag pattern, so the bench sweeps every code against all sixteen flag patterns.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;

    localparam int unsigned COND_W   = 4;
    localparam int unsigned STATE_W  = 8;
    localparam int unsigned MASK_W   = 4;
    localparam int unsigned KEEP_LSB = 5;

    // Condition encodings; the code value selects the test.
    typedef enum logic [COND_W-1:0] {
        CC_ZSET   = 4'b0000,
        CC_ZCLR   = 4'b0001,
        CC_CSET   = 4'b0010,
        CC_CCLR   = 4'b0011,
        CC_NSET   = 4'b0100,
        CC_NCLR   = 4'b0101,
        CC_VSET   = 4'b0110,
        CC_VCLR   = 4'b0111,
        CC_UHIGH  = 4'b1000,
        CC_ULOWEQ = 4'b1001,
        CC_SGE    = 4'b1010,
        CC_SLT    = 4'b1011,
        CC_SGT    = 4'b1100,
        CC_SLE    = 4'b1101,
        CC_ALWAYS = 4'b1110,
        CC_ALWAYS2= 4'b1111
    } cond_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [STATE_W-1:0] it;
    } it_regs_t;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_exec_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  flags_t            flags_i,
    output logic              pass_o
);

    logic ge_w;
    logic hi_w;
    cond_code_e code_w;

    always_comb begin
        code_w = cond_code_e'(cond_i);
        ge_w   = (flags_i.n == flags_i.v);
        hi_w   = flags_i.c & ~flags_i.z;
        unique case (code_w)
            CC_ZSET:    pass_o =  flags_i.z;
            CC_ZCLR:    pass_o = ~flags_i.z;
            CC_CSET:    pass_o =  flags_i.c;
            CC_CCLR:    pass_o = ~flags_i.c;
            CC_NSET:    pass_o =  flags_i.n;
            CC_NCLR:    pass_o = ~flags_i.n;
            CC_VSET:    pass_o =  flags_i.v;
            CC_VCLR:    pass_o = ~flags_i.v;
            CC_UHIGH:   pass_o =  hi_w;
            CC_ULOWEQ:  pass_o = ~hi_w;
            CC_SGE:     pass_o =  ge_w;
            CC_SLT:     pass_o = ~ge_w;
            CC_SGT:     pass_o = ~flags_i.z & ge_w;
            CC_SLE:     pass_o =  flags_i.z | ~ge_w;
            CC_ALWAYS,
            CC_ALWAYS2: pass_o = 1'b1;
            default:    pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/it_tracker.sv
module it_tracker
    import cond_exec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] value_i,
    output logic [STATE_W-1:0] state_o,
    output logic               active_o
);

    localparam int unsigned SHIFT_W = KEEP_LSB;

    it_regs_t regs_d;
    it_regs_t regs_q;

    logic [STATE_W-1:0] stepped_w;
    logic               active_w;

    assign active_w = |regs_q.it[MASK_W-1:0];

    always_comb begin
        stepped_w = {regs_q.it[STATE_W-1:KEEP_LSB],
                     regs_q.it[SHIFT_W-2:0], 1'b0};
        if (stepped_w[MASK_W-1:0] == '0) begin
            stepped_w = '0;
        end

        regs_d = regs_q;
        if (load_i) begin
            regs_d.it = value_i;
        end else if (issue_i && active_w) begin
            regs_d.it = stepped_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o  = regs_q.it;
    assign active_o = active_w;

endmodule

// File: rtl/cond_exec_tracker.sv
module cond_exec_tracker
    import cond_exec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic               it_load_i,
    input  logic [STATE_W-1:0] it_value_i,
    input  logic [COND_W-1:0]  insn_cond_i,
    input  logic               flag_n_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    input  logic               flag_v_i,
    output logic               exec_o,
    output logic               in_block_o,
    output logic [STATE_W-1:0] it_state_o
);

    logic [STATE_W-1:0] state_w;
    logic               active_w;
    logic [COND_W-1:0]  eff_cond_w;
    flags_t             flags_w;

    it_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .issue_i  (issue_i),
        .load_i   (it_load_i),
        .value_i  (it_value_i),
        .state_o  (state_w),
        .active_o (active_w)
    );

    always_comb begin
        flags_w = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
        eff_cond_w = active_w ? state_w[STATE_W-1:STATE_W-COND_W] : insn_cond_i;
    end

    cond_eval u_eval (
        .cond_i  (eff_cond_w),
        .flags_i (flags_w),
        .pass_o  (exec_o)
    );

    assign in_block_o = active_w;
    assign it_state_o = state_w;

endmodule

// File: rtl/cond_exec_tracker_chk.sv
module cond_exec_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       issue_i,
    input logic       it_load_i,
    input logic [7:0] it_value_i,
    input logic [3:0] insn_cond_i,
    input logic       flag_n_i,
    input logic       flag_z_i,
    input logic       flag_c_i,
    input logic       flag_v_i,
    input logic       exec_o,
    input logic       in_block_o,
    input logic [7:0] it_state_o
);

    logic advancing;
    assign advancing = issue_i && !it_load_i && in_block_o;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (it_state_o == 8'h00)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        it_load_i |=> (it_state_o == $past(it_value_i))); // R8

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (advancing && it_state_o[2:0] != 3'b000) |=>
        (it_state_o == {$past(it_state_o[7:5]), $past(it_state_o[3:0]), 1'b0})); // R9

    AST_STEP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (advancing && it_state_o[2:0] == 3'b000) |=> (it_state_o == 8'h00)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!it_load_i && !advancing) |=> $stable(it_state_o)); // R11

    always_comb begin
        if (!in_block_o && insn_cond_i[3:1] == 3'b111) begin
            AST_ALWAYS_RUNS: assert (exec_o); // R2
        end
        if (!in_block_o && insn_cond_i == 4'b0000) begin
            AST_ZERO_TEST: assert (exec_o == flag_z_i); // R3
        end
        if (!in_block_o && insn_cond_i == 4'b1000) begin
            AST_UHIGH_TEST: assert (exec_o == (flag_c_i && !flag_z_i)); // R4
        end
        if (!in_block_o && insn_cond_i == 4'b1010) begin
            AST_SGE_TEST: assert (exec_o == (flag_n_i == flag_v_i)); // R5
        end
    end

endmodule

bind cond_exec_tracker cond_exec_tracker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .it_load_i   (it_load_i),
    .it_value_i  (it_value_i),
    .insn_cond_i (insn_cond_i),
    .flag_n_i    (flag_n_i),
    .flag_z_i    (flag_z_i),
    .flag_c_i    (flag_c_i),
    .flag_v_i    (flag_v_i),
    .exec_o      (exec_o),
    .in_block_o  (in_block_o),
    .it_state_o  (it_state_o)
);

// File: tb/cond_exec_tracker_bench.sv
`timescale 1ns/1ps
module cond_exec_tracker_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_i = 1'b0;
    logic       it_load_i = 1'b0;
    logic [7:0] it_value_i = 8'h00;
    logic [3:0] insn_cond_i = 4'b1110;
    logic       flag_n_i = 1'b0;
    logic       flag_z_i = 1'b0;
    logic       flag_c_i = 1'b0;
    logic       flag_v_i = 1'b0;
    logic       exec_o;
    logic       in_block_o;
    logic [7:0] it_state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_exec_tracker u_cond_exec_tracker (
        .clk(clk), .rst(rst), .issue_i(issue_i), .it_load_i(it_load_i),
        .it_value_i(it_value_i), .insn_cond_i(insn_cond_i),
        .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i),
        .flag_v_i(flag_v_i), .exec_o(exec_o), .in_block_o(in_block_o),
        .it_state_o(it_state_o)
    );

    // Expected condition result, written from the requirement text.
    function automatic bit want_pass(input logic [3:0] cc, input logic [3:0] f);
        bit n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !(c && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_flags(input logic [3:0] f);
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        #1;
        check("R1 state", it_state_o, 8'h00);
        check("R1 in_block", {7'd0, in_block_o}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic sweep(input logic [3:0] lo, input logic [3:0] hi, input string req);
        for (int cc = int'(lo); cc <= int'(hi); cc++) begin
            for (int f = 0; f < 16; f++) begin
                insn_cond_i = 4'(cc);
                set_flags(4'(f));
                #1;
                check(req, {7'd0, exec_o}, {7'd0, want_pass(4'(cc), 4'(f))});
            end
        end
    endtask

    task automatic t_table();
        sweep(4'd14, 4'd15, "R2");
        sweep(4'd0, 4'd7, "R3");
        sweep(4'd8, 4'd9, "R4");
        sweep(4'd10, 4'd11, "R5");
        sweep(4'd12, 4'd13, "R6");
    endtask

    task automatic t_comb_path();
        insn_cond_i = 4'd0;
        set_flags(4'b0100);
        #1;
        check("R12 z set", {7'd0, exec_o}, 8'h01);
        set_flags(4'b0000);
        #1;
        check("R12 z clear same cycle", {7'd0, exec_o}, 8'h00);
    endtask

    task automatic load(input logic [7:0] val);
        it_load_i = 1'b1;
        it_value_i = val;
        tick();
        it_load_i = 1'b0;
    endtask

    task automatic t_block_run();
        // Load 1011_0100: cond 1011 first, then 1010, then cleared.
        issue_i = 1'b0;
        load(8'b1011_0100);
        #1;
        check("R8 load", it_state_o, 8'hB4);
        check("R7 active", {7'd0, in_block_o}, 8'h01);
        insn_cond_i = 4'b1110;
        set_flags(4'b1000);
        #1;
        check("R7 block cond ignores insn", {7'd0, exec_o}, 8'h01);
        set_flags(4'b0000);
        #1;
        check("R7 block cond false", {7'd0, exec_o}, 8'h00);
        tick();
        check("R11 hold no issue", it_state_o, 8'hB4);
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
        check("R9 advance", it_state_o, 8'hA8);
        #1;
        check("R7 new cond 1010", {7'd0, exec_o}, 8'h01);
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
        check("R10 clear at end", it_state_o, 8'h00);
        check("R10 inactive", {7'd0, in_block_o}, 8'h00);
    endtask

    task automatic t_long_block();
        load(8'b0001_0001);
        issue_i = 1'b1;
        tick();
        check("R9 low bit shift", it_state_o, 8'h02);
        tick();
        check("R9 keep high drop", it_state_o, 8'h04);
        tick();
        check("R9 into bit4", it_state_o, 8'h08);
        tick();
        check("R10 drop bit4 clear", it_state_o, 8'h00);
        issue_i = 1'b0;
        load(8'hE3);
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
        check("R9 high bits kept", it_state_o, 8'hE6);
    endtask

    task automatic t_load_priority();
        load(8'h3C);
        issue_i = 1'b1;
        it_load_i = 1'b1;
        it_value_i = 8'h51;
        tick();
        it_load_i = 1'b0;
        issue_i = 1'b0;
        check("R8 load over advance", it_state_o, 8'h51);
    endtask

    task automatic t_idle_issue();
        load(8'hF0);
        check("R7 inactive when low zero", {7'd0, in_block_o}, 8'h00);
        insn_cond_i = 4'd1;
        set_flags(4'b0100);
        #1;
        check("R7 own cond used", {7'd0, exec_o}, 8'h00);
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
        check("R11 no advance idle", it_state_o, 8'hF0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_table();
        t_comb_path();
        t_block_run();
        t_long_block();
        t_load_priority();
        t_idle_issue();
        rst = 1'b1;
        tick();
        #1;
        check("R1 reset mid run", it_state_o, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule